// File: doc/BRIEF.md
# Serial Bus Collision Supervisor

This block supervises the transmit side of a serial port whose data line is shared with other drivers through an open-drain connection. It works for single-wire links and for links with a transfer clock. While a frame is being sent, it compares the level the port puts on its transmit pin with the level read back from the receive pin. A difference seen at a sampling instant is a bus collision. The block latches it as a request bit for the interrupt logic. A mode word selects three behaviours:

- the sampling instant, either a transfer-clock rising edge or a timer overflow pulse;
- whether a collision automatically withdraws the transmit enable;
- whether a new frame must wait for a falling edge on the receive line before it starts.

The frame shifter, the baud generator and the timer are outside the block. The shifter asks for a frame with `frame_req`, marks its end with `frame_end`, and supplies the current bit on `shift_bit`. The block tells it when to shift with `shift_en` and puts the bit on `txd`. The receive line arrives asynchronously. It passes through a two-flop synchronizer before it is compared or searched for edges. The transfer-clock edge and the timer overflow are one-cycle enables in the system clock domain.

Top module: `sbc_guard`

## Requirements
- R1: After a synchronous reset, `txd` is 1 and `shift_en`, `tx_en` and `col_req` are 0. Every mode field is 0.
- R2: While no frame is running (`shift_en` low), `txd` stays 1 and sampling strobes never set `col_req`. This holds even when `tx_en` is 1 and the receive line is low.
- R3: With mode bit 4 at 0, a `xfer_rise` pulse during a running frame compares the synchronized receive level with `txd`. A difference sets `col_req` at the next clock edge. `tmr_ovf` pulses are ignored in this mode.
- R4: With mode bit 4 at 1, the comparison is made on `tmr_ovf` pulses instead. `xfer_rise` pulses are then ignored.
- R5: A sampling strobe that finds the receive level equal to `txd` leaves `col_req` at 0. This applies whether both levels are 0 or both are 1.
- R6: `col_req` stays at 1 until `col_clr` is pulsed. It reads 0 from the clock edge after the clear.
- R7: When a new collision and `col_clr` fall in the same cycle, `col_req` stays at 1.
- R8: With mode bit 5 at 1, the edge that sets `col_req` also forces `tx_en` to 0. One edge later the frame stops: `shift_en` goes to 0 and `txd` returns to 1.
- R9: With mode bit 5 at 0, a collision leaves `tx_en` and the running frame unchanged.
- R10: With mode bit 6 at 1, a frame request puts the transmitter into a waiting state. There `txd` is 1 and `shift_en` is 0 until a falling edge reaches the synchronized receive line. The first bit is driven on the third clock edge after the receive pin falls.
- R11: With mode bit 6 at 0, a frame request with `tx_en` at 1 starts shifting at the next edge. From that edge `txd` carries `shift_bit`. `frame_end` or a cleared `tx_en` returns the block to idle at the following edge.
- R12: `txen_wr` loads `txen_val` into `tx_en` at the next edge. A collision that auto-clears in the same cycle overrides a write of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode word |
| mode_wdata | input | 8 | Mode word: bit 4 sampling select, bit 5 auto drop, bit 6 start on falling edge |
| txen_wr | input | 1 | Software write strobe for transmit enable |
| txen_val | input | 1 | Value written into transmit enable |
| col_clr | input | 1 | Software clear of the collision request |
| xfer_rise | input | 1 | One-cycle pulse at each transfer-clock rising edge |
| tmr_ovf | input | 1 | One-cycle timer overflow pulse |
| frame_req | input | 1 | Shifter has a frame to send |
| frame_end | input | 1 | Shifter finished its frame |
| shift_bit | input | 1 | Current bit from the shifter |
| rxd | input | 1 | Asynchronous receive pin readback |
| txd | output | 1 | Registered transmit pin level |
| shift_en | output | 1 | Frame running, shifter may advance |
| tx_en | output | 1 | Transmit enable |
| col_req | output | 1 | Latched bus collision request |

## Verification
Every result reaches the ports one clock edge after its cause:
- a strobe seen in a cycle sets `col_req` at the next edge;
- an auto drop clears `tx_en` at that same edge and idles the transmitter one edge later;
- a software write or clear shows after one edge;
- a frame request starts the frame after one edge.

The receive pin is different, because the synchronizer adds two edges and the start logic one more. The bench therefore changes `rxd` and waits three edges before it expects the first bit. It also lets the pin settle for three cycles before any strobe that depends on it. Inputs change on the falling clock edge and outputs are read on the falling edge after the edge where the result is due, so each check lands in the exact cycle the requirement names.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  // bit positions of the mode word fields (decoded by the control register)
  localparam int MODE_W    = 8;
  localparam int SEL_BIT   = 4;
  localparam int AUTO_BIT  = 5;
  localparam int START_BIT = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_RUN  = 2'd2
  } tx_state_e;

  typedef struct packed {
    logic start_on_fall;
    logic auto_drop;
    logic ovf_sample;
  } mode_t;
endpackage

// File: rtl/sbc_rx_sync.sv
module sbc_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rxd_async,
  output logic rxd_s,
  output logic rxd_fall
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b1;
          else     sync_q[0] <= rxd_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b1;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sync_q[LAST];
  end

  assign rxd_s    = sync_q[LAST];
  assign rxd_fall = prev_q & ~sync_q[LAST];
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
#(
  parameter int W = MODE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_wr,
  input  logic [W-1:0] mode_wdata,
  input  logic         txen_wr,
  input  logic         txen_val,
  input  logic         col_clr,
  input  logic         col_hit,
  output mode_t        mode,
  output logic         tx_en,
  output logic         col_req
);
  logic spare_unused;
  assign spare_unused = ^mode_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= '0;
      tx_en   <= 1'b0;
      col_req <= 1'b0;
    end else begin
      if (mode_wr) begin
        mode.ovf_sample    <= mode_wdata[SEL_BIT];
        mode.auto_drop     <= mode_wdata[AUTO_BIT];
        mode.start_on_fall <= mode_wdata[START_BIT];
      end
      // hardware drop wins over a software write
      if (col_hit && mode.auto_drop) tx_en <= 1'b0;
      else if (txen_wr)              tx_en <= txen_val;
      // a fresh collision wins over a clear
      if (col_hit)      col_req <= 1'b1;
      else if (col_clr) col_req <= 1'b0;
    end
  end
endmodule

// File: rtl/sbc_sampler.sv
module sbc_sampler (
  input  logic ovf_sample,
  input  logic xfer_rise,
  input  logic tmr_ovf,
  input  logic running,
  input  logic tx_en,
  input  logic txd,
  input  logic rxd_s,
  output logic col_hit
);
  logic strobe;

  always_comb begin
    strobe  = ovf_sample ? tmr_ovf : xfer_rise;
    col_hit = running & tx_en & strobe & (rxd_s ^ txd);
  end
endmodule

// File: rtl/sbc_tx_fsm.sv
module sbc_tx_fsm
  import sbc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic start_on_fall,
  input  logic frame_req,
  input  logic frame_end,
  input  logic rxd_fall,
  input  logic shift_bit,
  output logic txd,
  output logic shift_en
);
  tx_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (tx_en && frame_req) st_d = start_on_fall ? ST_PEND : ST_RUN;
      ST_PEND: begin
        if (!tx_en)        st_d = ST_IDLE;
        else if (rxd_fall) st_d = ST_RUN;
      end
      ST_RUN:  if (!tx_en || frame_end) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      txd  <= 1'b1;
    end else begin
      st_q <= st_d;
      txd  <= (st_d == ST_RUN) ? shift_bit : 1'b1;
    end
  end

  assign shift_en = (st_q == ST_RUN);
endmodule

// File: rtl/sbc_guard.sv
module sbc_guard
  import sbc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              txen_wr,
  input  logic              txen_val,
  input  logic              col_clr,
  input  logic              xfer_rise,
  input  logic              tmr_ovf,
  input  logic              frame_req,
  input  logic              frame_end,
  input  logic              shift_bit,
  input  logic              rxd,
  output logic              txd,
  output logic              shift_en,
  output logic              tx_en,
  output logic              col_req
);
  mode_t mode_q;
  logic  rxd_s, rxd_fall, col_hit, auto_drop_w;

  sbc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rxd_async(rxd), .rxd_s(rxd_s), .rxd_fall(rxd_fall)
  );

  sbc_ctrl #(.W(MODE_W)) u_ctrl (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .txen_wr(txen_wr), .txen_val(txen_val), .col_clr(col_clr),
    .col_hit(col_hit), .mode(mode_q), .tx_en(tx_en), .col_req(col_req)
  );

  sbc_sampler u_smp (
    .ovf_sample(mode_q.ovf_sample), .xfer_rise(xfer_rise), .tmr_ovf(tmr_ovf),
    .running(shift_en), .tx_en(tx_en), .txd(txd), .rxd_s(rxd_s),
    .col_hit(col_hit)
  );

  sbc_tx_fsm u_fsm (
    .clk(clk), .rst(rst), .tx_en(tx_en), .start_on_fall(mode_q.start_on_fall),
    .frame_req(frame_req), .frame_end(frame_end), .rxd_fall(rxd_fall),
    .shift_bit(shift_bit), .txd(txd), .shift_en(shift_en)
  );

  assign auto_drop_w = mode_q.auto_drop;
endmodule

// File: rtl/sbc_guard_chk.sv
module sbc_guard_chk (
  input logic clk,
  input logic rst,
  input logic txen_wr,
  input logic txen_val,
  input logic col_clr,
  input logic txd,
  input logic shift_en,
  input logic tx_en,
  input logic col_req,
  input logic auto_drop
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> !$rose(col_req));

  // R2
  idle_txd_high_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |-> txd);

  // R6
  col_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (col_req && !col_clr) |=> col_req);

  // R8
  auto_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(col_req) && $past(auto_drop)) |-> !tx_en);

  // R12
  txen_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> $past(txen_wr && txen_val));

  // R3
  col_only_running_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(col_req) |-> $past(shift_en));
endmodule

bind sbc_guard sbc_guard_chk chk_i (
  .clk(clk), .rst(rst), .txen_wr(txen_wr), .txen_val(txen_val),
  .col_clr(col_clr), .txd(txd), .shift_en(shift_en), .tx_en(tx_en),
  .col_req(col_req), .auto_drop(auto_drop_w)
);

// File: tb/sbc_guard_tb.sv
module sbc_guard_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_wr = 0, txen_wr = 0, txen_val = 0, col_clr = 0;
  logic xfer_rise = 0, tmr_ovf = 0, frame_req = 0, frame_end = 0;
  logic shift_bit = 1, rxd = 1;
  logic [7:0] mode_wdata = '0;
  logic txd, shift_en, tx_en, col_req;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sbc_guard dut_i (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .txen_wr(txen_wr), .txen_val(txen_val), .col_clr(col_clr),
    .xfer_rise(xfer_rise), .tmr_ovf(tmr_ovf), .frame_req(frame_req),
    .frame_end(frame_end), .shift_bit(shift_bit), .rxd(rxd),
    .txd(txd), .shift_en(shift_en), .tx_en(tx_en), .col_req(col_req)
  );

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  // mode: bit4 sample on overflow, bit5 auto drop, bit6 start on falling edge
  task automatic start_frame(input logic sel, input logic auto, input logic strt, input logic b);
    mode_wr = 1; mode_wdata = 8'h00;
    mode_wdata[4] = sel; mode_wdata[5] = auto; mode_wdata[6] = strt;
    txen_wr = 1; txen_val = 1;
    cyc(1);
    mode_wr = 0; txen_wr = 0;
    frame_req = 1; shift_bit = b;
    cyc(1);
    frame_req = 0;
  endtask

  task automatic cleanup();
    frame_end = 1; txen_wr = 1; txen_val = 0; col_clr = 1; rxd = 1;
    xfer_rise = 0; tmr_ovf = 0;
    cyc(1);
    frame_end = 0; txen_wr = 0; col_clr = 0;
    cyc(3);
  endtask

  task automatic t_reset();
    chk("R1", "txd", txd, 1'b1);
    chk("R1", "shift_en", shift_en, 1'b0);
    chk("R1", "tx_en", tx_en, 1'b0);
    chk("R1", "col_req", col_req, 1'b0);
  endtask

  task automatic t_idle();
    txen_wr = 1; txen_val = 1; rxd = 0;
    cyc(1); txen_wr = 0;
    cyc(3);
    xfer_rise = 1; tmr_ovf = 1;
    cyc(1); xfer_rise = 0; tmr_ovf = 0;
    cyc(1);
    chk("R2", "idle col_req", col_req, 1'b0);
    chk("R2", "idle txd", txd, 1'b1);
    cleanup();
  endtask

  task automatic t_sel_clk();
    start_frame(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R11", "shift_en after request", shift_en, 1'b1);
    chk("R11", "txd carries bit", txd, 1'b0);
    tmr_ovf = 1; cyc(1); tmr_ovf = 0;
    chk("R3", "overflow ignored", col_req, 1'b0);
    xfer_rise = 1; cyc(1); xfer_rise = 0;
    chk("R3", "clock edge collision", col_req, 1'b1);
    chk("R9", "tx_en kept", tx_en, 1'b1);
    cyc(1);
    chk("R9", "frame keeps running", shift_en, 1'b1);
    cyc(2);
    chk("R6", "held", col_req, 1'b1);
    col_clr = 1; xfer_rise = 1; cyc(1); col_clr = 0; xfer_rise = 0;
    chk("R7", "collision beats clear", col_req, 1'b1);
    col_clr = 1; cyc(1); col_clr = 0;
    chk("R6", "cleared", col_req, 1'b0);
    frame_end = 1; cyc(1); frame_end = 0;
    chk("R11", "frame_end idles", shift_en, 1'b0);
    chk("R11", "txd idle high", txd, 1'b1);
    cleanup();
  endtask

  task automatic t_sel_ovf();
    start_frame(1'b1, 1'b0, 1'b0, 1'b0);
    xfer_rise = 1; cyc(1); xfer_rise = 0;
    chk("R4", "clock edge ignored", col_req, 1'b0);
    tmr_ovf = 1; cyc(1); tmr_ovf = 0;
    chk("R4", "overflow collision", col_req, 1'b1);
    cleanup();
  endtask

  task automatic t_match();
    start_frame(1'b0, 1'b0, 1'b0, 1'b1);
    xfer_rise = 1; cyc(1); xfer_rise = 0;
    chk("R5", "both high", col_req, 1'b0);
    shift_bit = 0; rxd = 0; cyc(3);
    xfer_rise = 1; cyc(1); xfer_rise = 0;
    chk("R5", "both low", col_req, 1'b0);
    cleanup();
  endtask

  task automatic t_auto();
    start_frame(1'b0, 1'b1, 1'b0, 1'b0);
    txen_wr = 1; txen_val = 1; xfer_rise = 1;
    cyc(1); txen_wr = 0; xfer_rise = 0;
    chk("R8", "col_req set", col_req, 1'b1);
    chk("R12", "drop beats write", tx_en, 1'b0);
    cyc(1);
    chk("R8", "frame stopped", shift_en, 1'b0);
    chk("R8", "txd high", txd, 1'b1);
    cleanup();
    txen_wr = 1; txen_val = 1; cyc(1); txen_wr = 0;
    chk("R12", "software set", tx_en, 1'b1);
    txen_wr = 1; txen_val = 0; cyc(1); txen_wr = 0;
    chk("R12", "software clear", tx_en, 1'b0);
  endtask

  task automatic t_start_fall();
    start_frame(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R10", "pending no shift", shift_en, 1'b0);
    chk("R10", "pending txd high", txd, 1'b1);
    cyc(3);
    chk("R10", "still pending", shift_en, 1'b0);
    rxd = 0;
    cyc(1);
    chk("R10", "edge+1 pending", shift_en, 1'b0);
    cyc(1);
    chk("R10", "edge+2 pending", shift_en, 1'b0);
    chk("R10", "edge+2 txd", txd, 1'b1);
    cyc(1);
    chk("R10", "edge+3 running", shift_en, 1'b1);
    chk("R10", "edge+3 first bit", txd, 1'b0);
    cleanup();
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc(1);
    t_reset();
    t_idle();
    t_sel_clk();
    t_sel_ovf();
    t_match();
    t_auto();
    t_start_fall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule